// File: doc/BRIEF.md
# Hardware Task Slot Scheduler with Skip Counters

This block decides, on every clock, which of four hardware tasks in one processor core may issue an instruction. A programmable table of sixteen slots sets the base rotation: a slot pointer steps through the table one entry per cycle, and the task named in the current entry owns that cycle. A plain table of this size cannot give any task less than one cycle in sixteen. A background task, such as a debug monitor, would still take that share and disturb the timing of the other tasks.

To push that share lower, each task has a skip counter with a programmable reload. When a task with a non-zero reload reaches its own slot, it gives the slot up until its counter has passed the reload value. The slots it gives up, and the slots of tasks that are switched off, go to a fallback task. The fallback is either a fixed alternate task or the task that issued on the previous cycle, chosen by a mode bit. If the fallback task is switched off as well, the cycle stays idle. All configuration goes into shadow registers and only takes effect when the pointer wraps, so the schedule never runs from a half-written table.

The grant output is a plain per-cycle control signal with no handshake. The consumer has no way to push back: a grant is either used in its cycle or lost.

Top module: `task_slot_sched`

## Requirements
- R1: After reset every table entry names task 0, all skip reloads are 0, the fallback is alternate task 0 in fixed mode, and the previous-issuer record is task 0. With `task_en` = 4'b0001 the grant is then task 0 and valid on every cycle.
- R2: The slot pointer starts at 0 after reset, advances by one on every clock and wraps from 15 to 0. The entry it selects names the owner of the cycle.
- R3: A write with `cfg_addr` 0..15 loads table entry `cfg_addr` from `cfg_wdata[1:0]`, which holds a 2-bit task index.
- R4: A write with `cfg_addr` 16..19 sets the skip reload of task `cfg_addr`-16 from `cfg_wdata`. With reload N > 0 the owner issues on one of every N+1 of its own enabled slots: the counter runs 0..N, the owner issues when the counter equals N, and the counter then returns to 0. With reload 0 the owner issues on every one of its enabled slots.
- R5: A write with `cfg_addr` 20 sets the alternate task from `cfg_wdata[1:0]` and the fallback mode from `cfg_wdata[2]`. In mode 0 a slot the owner does not use goes to the alternate task.
- R6: In mode 1 a slot the owner does not use goes to the task that received the last valid grant.
- R7: A task whose `task_en` bit is 0 never receives a grant. Its slots go to the fallback task, and its skip counter does not advance.
- R8: If the owner does not issue and the fallback task is disabled, `grant_valid` is 0 for that cycle.
- R9: Configuration writes land in shadow registers and become active at the edge on which the pointer moves from 15 to 0. A skip counter is cleared at that edge when its task's reload value changes.
- R10: If a task owns one slot of the table and has reload 15, it gets exactly 2 grants in 512 cycles, which is 1/256 of the cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address: 0..15 table entry, 16..19 skip reload, 20 fallback |
| cfg_wdata | input | SKIP_W | Configuration write data |
| task_en | input | 4 | Per-task enable mask |
| grant_valid | output | 1 | A task issues this cycle |
| grant_task | output | 2 | Index of the task that issues |

## Verification
A wrong pointer or a wrong table entry shows up at the grant on the very next cycle. A skip counter that drifts, or that misses its clear at a wrap, shows up within one reload period of that task's own slots, as a grant moved to the fallback or the other way round. A bad previous-issuer record or a bad fallback selection shows up on the first skipped or disabled slot. A shadow value that is committed too early shows up within 16 cycles. The bench therefore compares the grant against an independent model on every single cycle, and it also counts grants over a long window to confirm the 1/256 share.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int TASKS     = 4;
  localparam int TID_W     = $clog2(TASKS);
  localparam int SLOTS     = 16;
  localparam int PTR_W     = $clog2(SLOTS);
  localparam int ADDR_W    = 5;
  localparam int SKIP_BASE = SLOTS;
  localparam int FB_ADDR   = SKIP_BASE + TASKS;

  typedef logic [TID_W-1:0] tid_t;

  typedef enum logic {
    FB_ALT  = 1'b0,
    FB_LAST = 1'b1
  } fb_mode_e;
endpackage

// File: rtl/slot_cfg_regs.sv
module slot_cfg_regs
  import sched_pkg::*;
#(
  parameter int SKIP_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [SKIP_W-1:0]                 wdata,
  input  logic                              commit,
  output logic [SLOTS-1:0][TID_W-1:0]       map_act,
  output logic [TASKS-1:0][SKIP_W-1:0]      rel_act,
  output tid_t                              alt_act,
  output fb_mode_e                          mode_act,
  output logic [TASKS-1:0]                  rel_changes
);
  logic [SLOTS-1:0][TID_W-1:0]  map_sh;
  logic [TASKS-1:0][SKIP_W-1:0] rel_sh;
  tid_t                         alt_sh;
  fb_mode_e                     mode_sh;

  // shadow copies: written at any time
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_sh  <= '0;
      rel_sh  <= '0;
      alt_sh  <= '0;
      mode_sh <= FB_ALT;
    end else if (we) begin
      if (addr < ADDR_W'(SKIP_BASE))
        map_sh[addr[PTR_W-1:0]] <= wdata[TID_W-1:0];
      else if (addr < ADDR_W'(FB_ADDR))
        rel_sh[addr[TID_W-1:0]] <= wdata;
      else if (addr == ADDR_W'(FB_ADDR)) begin
        alt_sh  <= wdata[TID_W-1:0];
        mode_sh <= fb_mode_e'(wdata[TID_W]);
      end
    end
  end

  // active copies: loaded only when the pointer wraps
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_act  <= '0;
      rel_act  <= '0;
      alt_act  <= '0;
      mode_act <= FB_ALT;
    end else if (commit) begin
      map_act  <= map_sh;
      rel_act  <= rel_sh;
      alt_act  <= alt_sh;
      mode_act <= mode_sh;
    end
  end

  for (genvar t = 0; t < TASKS; t++) begin : g_chg
    assign rel_changes[t] = (rel_sh[t] != rel_act[t]);
  end

  assert_hold_between_wraps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(map_act) && $stable(rel_act) && $stable(alt_act) && $stable(mode_act)));
endmodule

// File: rtl/skip_counters.sv
module skip_counters
  import sched_pkg::*;
#(
  parameter int SKIP_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  tid_t                         owner,
  input  logic                         owner_en,
  input  logic [TASKS-1:0][SKIP_W-1:0] rel_act,
  input  logic                         commit,
  input  logic [TASKS-1:0]             rel_changes,
  output logic                         owner_go
);
  logic [TASKS-1:0] hit;

  for (genvar t = 0; t < TASKS; t++) begin : g_task
    logic [SKIP_W-1:0] cnt;
    logic              mine;
    logic              adv;

    assign mine   = (owner == tid_t'(t));
    assign hit[t] = (rel_act[t] == '0) || (cnt == rel_act[t]);
    assign adv    = mine && owner_en && (rel_act[t] != '0);

    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt <= '0;
      else if (commit && rel_changes[t])
        cnt <= '0;
      else if (adv)
        cnt <= hit[t] ? '0 : cnt + 1'b1;
    end

    assert_wrap_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && hit[t] && !commit) |=> (cnt == '0));
    assert_no_advance_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mine && !owner_en && !commit) |=> $stable(cnt));
  end

  assign owner_go = owner_en && hit[owner];
endmodule

// File: rtl/grant_select.sv
module grant_select
  import sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  tid_t             owner,
  input  logic             owner_go,
  input  logic [TASKS-1:0] task_en,
  input  fb_mode_e         mode,
  input  tid_t             alt,
  output logic             valid,
  output tid_t             task_id
);
  tid_t last_q;
  tid_t fb;

  assign fb = (mode == FB_LAST) ? last_q : alt;

  always_comb begin
    valid   = 1'b0;
    task_id = owner;
    if (owner_go) begin
      valid   = 1'b1;
      task_id = owner;
    end else if (task_en[fb]) begin
      valid   = 1'b1;
      task_id = fb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      last_q <= '0;
    else if (valid)
      last_q <= task_id;
  end

  assert_last_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> (last_q == $past(task_id)));
endmodule

// File: rtl/task_slot_sched.sv
module task_slot_sched
  import sched_pkg::*;
#(
  parameter int SKIP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_addr,
  input  logic [SKIP_W-1:0] cfg_wdata,
  input  logic [3:0]        task_en,
  output logic              grant_valid,
  output logic [1:0]        grant_task
);
  logic [PTR_W-1:0]             ptr;
  logic                         commit;
  logic [SLOTS-1:0][TID_W-1:0]  map_act;
  logic [TASKS-1:0][SKIP_W-1:0] rel_act;
  tid_t                         alt_act;
  fb_mode_e                     mode_act;
  logic [TASKS-1:0]             rel_changes;
  tid_t                         owner;
  logic                         owner_go;
  tid_t                         gtask;

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr + 1'b1;
  end

  assign commit = (ptr == PTR_W'(SLOTS - 1));
  assign owner  = map_act[ptr];

  slot_cfg_regs #(.SKIP_W(SKIP_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .commit(commit), .map_act(map_act), .rel_act(rel_act), .alt_act(alt_act),
    .mode_act(mode_act), .rel_changes(rel_changes)
  );

  skip_counters #(.SKIP_W(SKIP_W)) skip_i (
    .clk(clk), .rst_n(rst_n), .owner(owner), .owner_en(task_en[owner]),
    .rel_act(rel_act), .commit(commit), .rel_changes(rel_changes), .owner_go(owner_go)
  );

  grant_select sel_i (
    .clk(clk), .rst_n(rst_n), .owner(owner), .owner_go(owner_go), .task_en(task_en),
    .mode(mode_act), .alt(alt_act), .valid(grant_valid), .task_id(gtask)
  );

  assign grant_task = gtask;

  assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == PTR_W'(SLOTS - 1)) |=> (ptr == '0));
  assert_grant_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> task_en[grant_task]);
  assert_owner_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_go && grant_valid) |-> (grant_task == owner));
endmodule

// File: tb/task_slot_sched_tb_top.sv
`timescale 1ns/1ps
module task_slot_sched_tb_top;
  localparam int SKIP_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [4:0]        cfg_addr = '0;
  logic [SKIP_W-1:0] cfg_wdata = '0;
  logic [3:0]        task_en = 4'b0001;
  logic              grant_valid;
  logic [1:0]        grant_task;

  always #2 clk = ~clk;

  task_slot_sched #(.SKIP_W(SKIP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .task_en(task_en),
    .grant_valid(grant_valid), .grant_task(grant_task)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string phase = "R1";

  // behavioural model
  int m_map_sh[16], m_map[16];
  int m_rel_sh[4], m_rel[4], m_cnt[4];
  int m_alt_sh, m_alt, m_mode_sh, m_mode, m_last, m_ptr;
  int e_valid, e_task;

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin m_map_sh[i] = 0; m_map[i] = 0; end
    for (int i = 0; i < 4; i++) begin m_rel_sh[i] = 0; m_rel[i] = 0; m_cnt[i] = 0; end
    m_alt_sh = 0; m_alt = 0; m_mode_sh = 0; m_mode = 0; m_last = 0; m_ptr = 0;
  endtask

  task automatic model_eval();
    int own, fb;
    bit go;
    own = m_map[m_ptr];
    go  = task_en[own] && (m_rel[own] == 0 || m_cnt[own] == m_rel[own]);
    fb  = (m_mode != 0) ? m_last : m_alt;
    if (go) begin e_valid = 1; e_task = own; end
    else if (task_en[fb]) begin e_valid = 1; e_task = fb; end
    else begin e_valid = 0; e_task = -1; end
  endtask

  task automatic model_clock();
    int own;
    own = m_map[m_ptr];
    if (task_en[own] && m_rel[own] != 0)
      m_cnt[own] = (m_cnt[own] == m_rel[own]) ? 0 : m_cnt[own] + 1;
    if (e_valid) m_last = e_task;
    if (m_ptr == 15) begin
      for (int t = 0; t < 4; t++) if (m_rel_sh[t] != m_rel[t]) m_cnt[t] = 0;
      m_map = m_map_sh; m_rel = m_rel_sh; m_alt = m_alt_sh; m_mode = m_mode_sh;
    end
    if (cfg_we) begin
      if (cfg_addr < 16) m_map_sh[cfg_addr] = int'(cfg_wdata[1:0]);
      else if (cfg_addr < 20) m_rel_sh[cfg_addr - 16] = int'(cfg_wdata);
      else if (cfg_addr == 20) begin
        m_alt_sh = int'(cfg_wdata[1:0]); m_mode_sh = int'(cfg_wdata[2]);
      end
    end
    m_ptr = (m_ptr + 1) % 16;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: compare away from the edge, then advance model
  task automatic step();
    int act;
    #1;
    model_eval();
    act = grant_valid ? int'(grant_task) : -1;
    check(act == e_task, phase, act, e_task);
    @(posedge clk);
    model_clock();
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = SKIP_W'(d);
    step();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic align();
    step();
    while (m_ptr != 0) step();
  endtask

  initial begin
    int hits;
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, only task 0 enabled
    phase = "R1"; run(20);
    // R2/R3: table programmed with a rotation, all enabled
    phase = "R3";
    for (int k = 0; k < 16; k++) wr(k, k % 4);
    task_en = 4'b1111;
    phase = "R2"; align(); run(40);
    // R9: mid-frame write, not active before the wrap
    phase = "R9"; run(5); wr(2, 3); wr(17, 2); run(30);
    // R4/R5: skip on task 3, alternate task 0
    phase = "R4"; wr(19, 3); wr(20, 0); align(); run(120);
    phase = "R5"; wr(20, 1); align(); run(64);
    // R6: previous-issuer mode
    phase = "R6"; wr(20, 4); align(); run(100);
    // R7: task 2 disabled, fallback alternate 1
    phase = "R7"; wr(20, 1); align(); task_en = 4'b1011; run(64);
    // R8: fallback itself disabled gives idle slots
    phase = "R8"; wr(20, 2); align(); run(48);
    task_en = 4'b0011; wr(20, 6); align(); run(48);
    // R10: one slot for task 1, reload 15
    phase = "R10"; task_en = 4'b0011;
    for (int k = 0; k < 16; k++) wr(k, (k == 5) ? 1 : 0);
    wr(16, 0); wr(17, 15); wr(18, 0); wr(19, 0); wr(20, 0);
    align(); align();
    hits = 0;
    for (int i = 0; i < 512; i++) begin
      #1;
      if (grant_valid && grant_task == 2'd1) hits++;
      #0;
      step_back();
    end
    check(hits == 2, "R10", hits, 2);
    // R1 again: reset restores defaults
    phase = "R1"; rst_n = 1'b0; task_en = 4'b0001;
    @(posedge clk); @(negedge clk); rst_n = 1'b1; model_reset();
    run(20);
    finish_run();
  end

  // step() already waits 1 ns before sampling; undo the extra delay here
  task automatic step_back();
    int act;
    model_eval();
    act = grant_valid ? int'(grant_task) : -1;
    check(act == e_task, phase, act, e_task);
    @(posedge clk);
    model_clock();
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      finish_run();
    end
  end
endmodule